// File: doc/BRIEF.md
# Circular-Buffer Rate Matcher

This block turns three equally long interleaved code streams into an output stream of any requested length. The streams are one systematic stream and two parity streams, and every entry carries a null flag. The block never copies the streams into a buffer of its own. It reads them directly from three external stream RAMs that share one address. It treats them as a single virtual ring, Kw = 3·Kπ positions long.

In that ring, the systematic stream comes first. The two parity streams follow, alternating one bit from each. Reading starts at an offset chosen by a two-bit redundancy version. Positions flagged null are passed over. Reading stops once the requested number of real bits has been sent:
- If fewer bits are asked for than the ring holds, the tail is punctured.
- If more are asked for, reading wraps back to position 0 and bits are repeated.

A run is launched with a one-cycle `start` pulse that carries Kπ, the output length E and the redundancy version. The block then streams bits with a valid strobe and ends with a one-cycle `done` pulse.

Top module: `rate_matcher`

## Requirements
- R1: After reset `outValid`, `done` and `rdEn` are low, and they stay low until a run is started.
- R2: Ring position p maps as follows. For p < Kπ it is systematic entry p. Otherwise, with q = p − Kπ, it is parity-1 entry q/2 when q is even and parity-2 entry q/2 when q is odd. Kπ must be a multiple of 32.
- R3: The first ring position read is k0 = R·(24·rv + 2), where R = Kπ/32. This is the offset for a ring of 96·R positions.
- R4: After position Kw − 1, reading continues at position 0, so a request longer than the ring repeats bits.
- R5: Exactly E valid output bits are produced per run. When E is below the number of usable bits, the later positions are never sent.
- R6: A ring position whose null flag is 1 produces no output bit and does not count toward E. The ring must hold at least one non-null entry.
- R7: `done` is high for exactly one cycle per run, in the cycle after the last valid bit. With E = 0, no valid bit appears and `done` still pulses once.
- R8: A `start` pulse while a run is in progress is ignored, along with the parameters it carries.
- R9: The stream RAMs have one cycle of read latency. A read is issued with `rdEn` and `rdAddr` in one cycle, and the flag and bit are taken on the following cycle. `rdEn` is high in the cycle right after `start` is accepted whenever E > 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a run (taken only when idle) |
| kPi | input | $clog2(32·MAX_ROWS+1) | Length of each stream, a multiple of 32 |
| eLen | input | $clog2(384·MAX_ROWS+1) | Number of output bits E |
| rv | input | 2 | Redundancy version |
| rdEn | output | 1 | Read strobe to the three stream RAMs |
| rdAddr | output | $clog2(32·MAX_ROWS) | Shared stream RAM address |
| sysBit | input | 1 | Systematic RAM data bit |
| sysNull | input | 1 | Systematic RAM null flag |
| par1Bit | input | 1 | Parity-1 RAM data bit |
| par1Null | input | 1 | Parity-1 RAM null flag |
| par2Bit | input | 1 | Parity-2 RAM data bit |
| par2Null | input | 1 | Parity-2 RAM null flag |
| outBit | output | 1 | Output bit |
| outValid | output | 1 | Output bit valid |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Each fault in the ring walk shows up at the ports in a distinct way:
- A wrong start offset or a wrong parity interleave changes the first bits of a run, so the error appears within a few cycles of `start`.
- A wrap fault only appears once a run crosses position Kw − 1.
- A miscounted null or a wrong count of E changes the number of bits before `done`, or moves `done` away from the cycle after the last valid bit. This is seen at the end of the run.

A mapping error between the pending read and the returned data corrupts the bits that follow a stream boundary.

// File: rtl/rm_pkg.sv
package rm_pkg;

  // Strobes from the run control to the ring walker
  typedef struct packed {
    logic load;  // latch run parameters and seed the ring position
    logic run;   // issue a read at the current position and advance
    logic take;  // the returned entry becomes an output bit
  } rmStrobe_t;

endpackage

// File: rtl/rm_control.sv
module rm_control
  import rm_pkg::*;
#(
  parameter int MAX_ROWS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [EW-1:0]         eLen,
  input  logic                  gotBit,
  output rmStrobe_t             strobe,
  output logic                  busy,
  output logic                  done
);
  localparam int KPI_MAX = MAX_ROWS * 32;
  localparam int EW      = $clog2(12 * KPI_MAX + 1);

  typedef enum logic {ST_IDLE, ST_RUN} ctlState_t;

  ctlState_t       state;
  logic [EW-1:0]   sentCnt;
  logic [EW-1:0]   eHold;
  logic            finished;

  assign finished = (sentCnt == eHold);
  assign busy     = (state == ST_RUN);

  always_comb begin
    strobe.load = (state == ST_IDLE) && start;
    strobe.run  = (state == ST_RUN) && !finished;
    strobe.take = (state == ST_RUN) && !finished && gotBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sentCnt <= '0;
      eHold   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_RUN;
          sentCnt <= '0;
          eHold   <= eLen;
        end
        ST_RUN: begin
          if (finished) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else if (strobe.take) begin
            sentCnt <= sentCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rm_datapath.sv
module rm_datapath
  import rm_pkg::*;
#(
  parameter int MAX_ROWS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  rmStrobe_t       strobe,
  input  logic [KW-1:0]   kPi,
  input  logic [1:0]      rv,
  output logic            rdEn,
  output logic [AW-1:0]   rdAddr,
  input  logic            sysBit,
  input  logic            sysNull,
  input  logic            par1Bit,
  input  logic            par1Null,
  input  logic            par2Bit,
  input  logic            par2Null,
  output logic            gotBit,
  output logic            outBit,
  output logic            outValid
);
  localparam int KPI_MAX = MAX_ROWS * 32;
  localparam int KW      = $clog2(KPI_MAX + 1);
  localparam int AW      = $clog2(KPI_MAX);
  localparam int PW      = $clog2(3 * KPI_MAX + 1);

  logic [PW-1:0] pos;
  logic [PW-1:0] posNext;
  logic [KW-1:0] kPiReg;
  logic [PW-1:0] ringLen;
  logic [PW-1:0] kPiWide;
  logic [PW-1:0] pastSys;
  logic [PW-1:0] k0Calc;
  logic [PW-1:0] rvTerm;
  logic          inSys;
  logic [1:0]    rdSel;
  logic [1:0]    pendSel;
  logic          pend;
  logic          selBit;
  logic          selNull;

  // ring position -> stream and address
  assign kPiWide = PW'(kPiReg);
  assign inSys   = (pos < kPiWide);
  assign pastSys = pos - kPiWide;
  assign rdSel   = inSys ? 2'd0 : (pastSys[0] ? 2'd2 : 2'd1);
  assign rdAddr  = inSys ? AW'(pos) : AW'(pastSys >> 1);
  assign rdEn    = strobe.run;
  assign posNext = (pos + 1'b1 == ringLen) ? '0 : pos + 1'b1;

  // start offset: rows * (24*rv + 2)
  assign rvTerm = PW'(rv) * PW'(24) + PW'(2);
  assign k0Calc = PW'(kPi[KW-1:5]) * rvTerm;

  always_comb begin
    unique case (pendSel)
      2'd1:    begin selBit = par1Bit; selNull = par1Null; end
      2'd2:    begin selBit = par2Bit; selNull = par2Null; end
      default: begin selBit = sysBit;  selNull = sysNull;  end
    endcase
  end

  assign gotBit = pend && !selNull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos      <= '0;
      kPiReg   <= '0;
      ringLen  <= '0;
      pend     <= 1'b0;
      pendSel  <= 2'd0;
      outBit   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.take;
      if (strobe.take) outBit <= selBit;
      if (strobe.load) begin
        kPiReg  <= kPi;
        ringLen <= PW'(kPi) * PW'(3);
        pos     <= k0Calc;
        pend    <= 1'b0;
      end else begin
        pend    <= strobe.run;
        pendSel <= rdSel;
        if (strobe.run) pos <= posNext;
      end
    end
  end
endmodule

// File: rtl/rate_matcher.sv
module rate_matcher
  import rm_pkg::*;
#(
  parameter int MAX_ROWS = 8
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                start,
  input  logic [$clog2(32*MAX_ROWS+1)-1:0]    kPi,
  input  logic [$clog2(384*MAX_ROWS+1)-1:0]   eLen,
  input  logic [1:0]                          rv,
  output logic                                rdEn,
  output logic [$clog2(32*MAX_ROWS)-1:0]      rdAddr,
  input  logic                                sysBit,
  input  logic                                sysNull,
  input  logic                                par1Bit,
  input  logic                                par1Null,
  input  logic                                par2Bit,
  input  logic                                par2Null,
  output logic                                outBit,
  output logic                                outValid,
  output logic                                done
);
  rmStrobe_t strobe;
  logic      gotBit;
  logic      ctlBusy;

  rm_control #(.MAX_ROWS(MAX_ROWS)) uCtl (
    .clk(clk), .rstN(rstN), .start(start), .eLen(eLen), .gotBit(gotBit),
    .strobe(strobe), .busy(ctlBusy), .done(done)
  );

  rm_datapath #(.MAX_ROWS(MAX_ROWS)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .kPi(kPi), .rv(rv),
    .rdEn(rdEn), .rdAddr(rdAddr),
    .sysBit(sysBit), .sysNull(sysNull), .par1Bit(par1Bit), .par1Null(par1Null),
    .par2Bit(par2Bit), .par2Null(par2Null),
    .gotBit(gotBit), .outBit(outBit), .outValid(outValid)
  );
endmodule

// File: rtl/rate_matcher_checker.sv
module rate_matcher_checker #(
  parameter int EW = 12
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          busy,
  input logic [EW-1:0] eLen,
  input logic          rdEn,
  input logic          outValid,
  input logic          done
);
  logic [EW-1:0] eSeen;
  logic [EW-1:0] bitsSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eSeen    <= '0;
      bitsSeen <= '0;
    end else if (start && !busy) begin
      eSeen    <= eLen;
      bitsSeen <= '0;
    end else if (outValid) begin
      bitsSeen <= bitsSeen + 1'b1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !rdEn);
  assert_no_excess_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> bitsSeen < eSeen);
  assert_full_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> bitsSeen == eSeen);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_alone_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !outValid);
  assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(rdEn, 2));
endmodule

bind rate_matcher rate_matcher_checker #(.EW($clog2(384*MAX_ROWS+1))) uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(ctlBusy), .eLen(eLen),
  .rdEn(rdEn), .outValid(outValid), .done(done)
);

// File: tb/sim_rate_matcher.sv
module sim_rate_matcher;
  localparam int MAX_ROWS = 8;
  localparam int KW = $clog2(32*MAX_ROWS+1);
  localparam int EW = $clog2(384*MAX_ROWS+1);
  localparam int AW = $clog2(32*MAX_ROWS);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, start, rdEn, outBit, outValid, done;
  logic [KW-1:0] kPi;
  logic [EW-1:0] eLen;
  logic [1:0] rv;
  logic [AW-1:0] rdAddr;
  logic sysBit, sysNull, par1Bit, par1Null, par2Bit, par2Null;

  rate_matcher #(.MAX_ROWS(MAX_ROWS)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .kPi(kPi), .eLen(eLen), .rv(rv),
    .rdEn(rdEn), .rdAddr(rdAddr),
    .sysBit(sysBit), .sysNull(sysNull), .par1Bit(par1Bit), .par1Null(par1Null),
    .par2Bit(par2Bit), .par2Null(par2Null),
    .outBit(outBit), .outValid(outValid), .done(done)
  );

  int total = 0, bad = 0;
  int fill = 0, sparse = 0;
  int cyc = 0, capN = 0, doneCnt = 0, lastValidCyc = 0, doneCyc = 0;
  logic capBits [0:4095];
  logic expBits [0:4095];

  function automatic logic memBit(int s, int a);
    return logic'((((a * 5 + s * 3 + a / 8) % 2) ^ ((a / 3) % 2)) != 0);
  endfunction

  function automatic logic memNull(int s, int a);
    if (s == 2) return logic'(sparse != 0 && (a % 16) == 5);
    return logic'(a < fill);
  endfunction

  // stream RAM model, one cycle read latency
  always @(posedge clk) begin
    if (rdEn) begin
      sysBit   <= memBit(0, int'(rdAddr));  sysNull  <= memNull(0, int'(rdAddr));
      par1Bit  <= memBit(1, int'(rdAddr));  par1Null <= memNull(1, int'(rdAddr));
      par2Bit  <= memBit(2, int'(rdAddr));  par2Null <= memNull(2, int'(rdAddr));
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (outValid) begin
      if (capN < 4096) capBits[capN] = outBit;
      capN++;
      lastValidCyc = cyc;
    end
    if (done) begin
      doneCnt++;
      doneCyc = cyc;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic runCase(int kp, int e, int r, bit intrude);
    int rows = kp / 32;
    int ring = 3 * kp;
    int k = rows * (24 * r + 2);
    int k0 = k;
    int n = 0;
    int mis = 0, firstMis = -1;
    while (n < e) begin
      int s, a;
      if (k < kp) begin s = 0; a = k; end
      else begin s = ((k - kp) % 2 == 0) ? 1 : 2; a = (k - kp) / 2; end
      if (!memNull(s, a)) begin expBits[n] = memBit(s, a); n++; end
      k = (k + 1) % ring;
    end
    @(negedge clk);
    capN = 0; doneCnt = 0;
    kPi = KW'(kp); eLen = EW'(e); rv = 2'(r); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (e > 0) begin
      int expAddr = (k0 < kp) ? k0 : (k0 - kp) / 2;
      check(rdEn == 1'b1, "R9", "rdEn after start", int'(rdEn), 1);
      check(int'(rdAddr) == expAddr, "R3", "first read address", int'(rdAddr), expAddr);
    end
    if (intrude) begin
      repeat (20) @(negedge clk);
      start = 1'b1; rv = 2'(r ^ 1); eLen = EW'(5); kPi = KW'(32);
      @(negedge clk);
      start = 1'b0;
    end
    while (doneCnt == 0) @(negedge clk);
    repeat (3) @(negedge clk);
    for (int i = 0; i < e && i < capN; i++)
      if (capBits[i] != expBits[i]) begin
        if (firstMis < 0) firstMis = i;
        mis++;
      end
    check(capN == e, intrude ? "R8" : "R5", $sformatf("bit count kp=%0d rv=%0d", kp, r), capN, e);
    check(mis == 0, (e > 2 * kp) ? "R4" : "R2", $sformatf("mismatches kp=%0d rv=%0d e=%0d first=%0d",
          kp, r, e, firstMis), mis, 0);
    check(doneCnt == 1, "R7", "done pulses", doneCnt, 1);
    if (e > 0)
      check(doneCyc == lastValidCyc + 1, "R7", "done cycle after last bit", doneCyc - lastValidCyc, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; kPi = '0; eLen = '0; rv = '0;
    repeat (4) @(negedge clk);
    check(outValid == 1'b0 && done == 1'b0 && rdEn == 1'b0, "R1", "idle outputs in reset",
          int'({outValid, done, rdEn}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && done == 1'b0 && rdEn == 1'b0, "R1", "idle outputs after reset",
          int'({outValid, done, rdEn}), 0);

    // no nulls: pure ordering, offset, puncture, wrap
    fill = 0; sparse = 0;
    for (int r = 0; r < 4; r++) begin
      runCase(32, 40, r, 1'b0);   // R5 puncture
      runCase(32, 96, r, 1'b0);   // exactly the ring
      runCase(32, 300, r, 1'b0);  // R4 repetition
    end
    // with null entries (R6)
    fill = 4; sparse = 1;
    for (int r = 0; r < 4; r++) begin
      runCase(64, 50, r, 1'b0);
      runCase(64, 192, r, 1'b0);
      runCase(64, 700, r, 1'b0);
    end
    runCase(64, 0, 2, 1'b0);      // R7 empty request
    runCase(64, 300, 1, 1'b1);    // R8 start while running
    runCase(256, 1000, 3, 1'b0);  // largest stream, R6 nulls
    runCase(256, 3072, 0, 1'b0);  // R4 maximum length

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule